// File: doc/BRIEF.md
# Cell Transmit Bus Receiver Port

This block sits on the physical-layer side of a byte-wide, multi-port cell transmit bus. The cell-layer master drives the bus clock, an active-low enable, a 5-bit port address, byte data and a start-of-cell flag. The port raises its cell-available output while it can take a complete cell. It then collects the bytes addressed to it, using the start-of-cell flag to find each cell's first byte.

Cells are built in a small byte buffer. A cell becomes visible on the local pop interface only after its last byte has arrived. A cell that is cut short by a new start-of-cell is discarded and reported with a one-cycle framing-error pulse. The local side reads bytes with a valid/ready pair, and a flag marks the first byte of each cell.

Top module: `cellbus_tx_port`

## Requirements
- R1: After reset, tx_clav is 1, out_valid is 0 and frm_err is 0.
- R2: A byte is taken only on a rising clock edge where tx_en_n is 0 and tx_addr equals PORT_ADDR. Address 5'h1F is the null address and can never be the port address. Bytes present while tx_en_n is 1 have no effect, and neither do bytes sent to any other address.
- R3: Bytes taken before the first start-of-cell are discarded. Bytes taken after a cell's last byte and before the next start-of-cell are also discarded.
- R4: A start-of-cell (tx_soc = 1) on a taken byte makes that byte byte 1 of a new cell. A cell is CELL_BYTES (53) bytes.
- R5: A cell is invisible on the local side until its last byte is taken. If the buffer held nothing, out_valid is 1 in the cycle after the edge that took that byte.
- R6: A start-of-cell that arrives before the current cell is complete discards the partial cell and starts a new one with that byte. frm_err is 1 for the single cycle after that edge.
- R7: tx_clav is 1 while at least CELL_BYTES bytes of buffer are free, and it stays 1 for a whole cell transfer. Once a cell is committed, tx_clav drops if fewer than CELL_BYTES bytes are free, and it rises again as soon as pops restore that space.
- R8: out_data presents the bytes in arrival order. out_first is 1 exactly on the first byte of each cell. A byte is popped on an edge with out_valid and out_ready both 1, and while out_ready is 0 the output holds steady.
- R9: A start-of-cell taken while tx_clav is 0 and no cell is in progress is ignored. The whole cell that follows it is dropped without a framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus byte clock, supplied by the cell-layer master |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_n | input | 1 | Active-low enable qualifying data and start-of-cell |
| tx_addr | input | ADDR_W | Port address being written or polled |
| tx_data | input | DATA_W | Cell byte from the master |
| tx_soc | input | 1 | High on the first byte of a cell |
| tx_clav | output | 1 | Room for a whole cell, or a transfer in progress |
| frm_err | output | 1 | One-cycle pulse when a partial cell is dropped |
| out_data | output | DATA_W | Oldest committed byte |
| out_first | output | 1 | out_data is the first byte of a cell |
| out_valid | output | 1 | A committed byte is available |
| out_ready | input | 1 | Local side takes the byte this cycle |

## Verification
The bench uses PORT_ADDR = 5, CELL_BYTES = 53 and BUF_CELLS = 2, so the buffer holds exactly two cells. With two cells of space, the full-buffer drop of tx_clav, its recovery after the 53rd pop and a refused third cell can all be reached with a handful of transfers. A sweep over all 32 addresses, including the null address, shows that only address 5 delivers a cell. Expected bytes come from an arithmetic pattern of seed and byte index.

// File: rtl/cellbus_pkg.sv
package cellbus_pkg;
   // Per-edge action decided by the framer for the cell store
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_START = 2'd1,
      ACT_BODY  = 2'd2,
      ACT_LAST  = 2'd3
   } cb_act_e;
endpackage

// File: rtl/cellbus_wrap_inc.sv
module cellbus_wrap_inc #(
   parameter int W     = 7,
   parameter int LIMIT = 106
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);
   generate
      if (LIMIT == (1 << W)) begin : g_pow2
         assign nxt = cur + W'(1);
      end else begin : g_cmp
         assign nxt = (cur == W'(LIMIT - 1)) ? '0 : cur + W'(1);
      end
   endgenerate
endmodule

// File: rtl/cellbus_framer.sv
module cellbus_framer
   import cellbus_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int CELL_BYTES = 53,
   parameter int PORT_ADDR  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              soc,
   input  logic              space_ok,
   output cb_act_e           act,
   output logic              abort,
   output logic              err,
   output logic              in_cell
);
   localparam int CNT_W = $clog2(CELL_BYTES + 1);

   logic [CNT_W-1:0] cnt;
   logic             take;

   assign take    = !en_n && (addr == ADDR_W'(PORT_ADDR));
   assign in_cell = (cnt != '0);

   always_comb begin
      act   = ACT_NONE;
      abort = 1'b0;
      if (take) begin
         if (soc) begin
            if (in_cell) begin
               abort = 1'b1;
               act   = ACT_START;
            end else if (space_ok) begin
               act = ACT_START;
            end
         end else if (in_cell) begin
            act = (cnt == CNT_W'(CELL_BYTES - 1)) ? ACT_LAST : ACT_BODY;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         err <= 1'b0;
      end else begin
         err <= abort;
         case (act)
            ACT_START: cnt <= CNT_W'(1);
            ACT_BODY:  cnt <= cnt + CNT_W'(1);
            ACT_LAST:  cnt <= '0;
            default:   cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/cellbus_store.sv
module cellbus_store
   import cellbus_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int DEPTH      = 106
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cb_act_e           act,
   input  logic              abort,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_first,
   output logic              rd_valid,
   output logic              space_ok
);
   localparam int PW = $clog2(DEPTH);
   localparam int UW = $clog2(DEPTH + 1);

   logic [DATA_W:0]   mem [DEPTH];
   logic [PW-1:0]     wr_ptr, cm_ptr, rd_ptr, base, base_nxt, rd_nxt;
   logic [UW-1:0]     used;
   logic              wr_en, commit, do_pop;

   assign base   = abort ? cm_ptr : wr_ptr;
   assign wr_en  = (act != ACT_NONE);
   assign commit = (act == ACT_LAST);
   assign do_pop = pop && rd_valid;

   cellbus_wrap_inc #(.W(PW), .LIMIT(DEPTH)) u_inc_wr (.cur(base),   .nxt(base_nxt));
   cellbus_wrap_inc #(.W(PW), .LIMIT(DEPTH)) u_inc_rd (.cur(rd_ptr), .nxt(rd_nxt));

   always_ff @(posedge clk) begin
      if (wr_en) mem[base] <= {act == ACT_START, wr_data};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         cm_ptr <= '0;
         rd_ptr <= '0;
         used   <= '0;
      end else begin
         if (wr_en)       wr_ptr <= base_nxt;
         else if (abort)  wr_ptr <= cm_ptr;
         if (commit)      cm_ptr <= base_nxt;
         if (do_pop)      rd_ptr <= rd_nxt;
         used <= used + (commit ? UW'(CELL_BYTES) : '0) - (do_pop ? UW'(1) : '0);
      end
   end

   assign rd_valid = (used != '0);
   assign rd_data  = mem[rd_ptr][DATA_W-1:0];
   assign rd_first = mem[rd_ptr][DATA_W];
   assign space_ok = (used <= UW'(DEPTH - CELL_BYTES));
endmodule

// File: rtl/cellbus_tx_port.sv
module cellbus_tx_port
   import cellbus_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int BUF_CELLS  = 2,
   parameter int PORT_ADDR  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en_n,
   input  logic [ADDR_W-1:0] tx_addr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_soc,
   output logic              tx_clav,
   output logic              frm_err,
   output logic [DATA_W-1:0] out_data,
   output logic              out_first,
   output logic              out_valid,
   input  logic              out_ready
);
   localparam int DEPTH     = CELL_BYTES * BUF_CELLS;
   localparam int NULL_ADDR = (1 << ADDR_W) - 1;

   generate
      if (PORT_ADDR == NULL_ADDR || PORT_ADDR < 0 || PORT_ADDR > NULL_ADDR) begin : g_bad_addr
         $error("PORT_ADDR must be a non-null address in range");
      end
      if (CELL_BYTES < 2) begin : g_bad_cell
         $error("CELL_BYTES must be at least 2");
      end
      if (BUF_CELLS < 1) begin : g_bad_buf
         $error("BUF_CELLS must be at least 1");
      end
   endgenerate

   cb_act_e act;
   logic    abort, in_cell, space_ok;

   cellbus_framer #(
      .ADDR_W(ADDR_W), .CELL_BYTES(CELL_BYTES), .PORT_ADDR(PORT_ADDR)
   ) u_framer (
      .clk(clk), .rst_n(rst_n), .en_n(tx_en_n), .addr(tx_addr), .soc(tx_soc),
      .space_ok(space_ok), .act(act), .abort(abort), .err(frm_err), .in_cell(in_cell)
   );

   cellbus_store #(
      .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .DEPTH(DEPTH)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .act(act), .abort(abort), .wr_data(tx_data),
      .pop(out_ready), .rd_data(out_data), .rd_first(out_first),
      .rd_valid(out_valid), .space_ok(space_ok)
   );

   assign tx_clav = in_cell || space_ok;
endmodule

// File: rtl/cellbus_tx_chk.sv
module cellbus_tx_chk #(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 8,
   parameter int PORT_ADDR = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_en_n,
   input logic [ADDR_W-1:0] tx_addr,
   input logic              tx_soc,
   input logic              tx_clav,
   input logic              frm_err,
   input logic [DATA_W-1:0] out_data,
   input logic              out_first,
   input logic              out_valid,
   input logic              out_ready
);
   logic sel;
   assign sel = !tx_en_n && (tx_addr == ADDR_W'(PORT_ADDR));

   p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frm_err |-> $past(sel && tx_soc));

   p_commit_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(sel));

   p_clav_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && tx_soc && tx_clav) |=> tx_clav);

   p_empty_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> tx_clav);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_first)));
endmodule

bind cellbus_tx_port cellbus_tx_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)
) i_chk (
   .clk(clk), .rst_n(rst_n), .tx_en_n(tx_en_n), .tx_addr(tx_addr), .tx_soc(tx_soc),
   .tx_clav(tx_clav), .frm_err(frm_err), .out_data(out_data), .out_first(out_first),
   .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/test_cellbus_tx_port.sv
module test_cellbus_tx_port;
   localparam int AW = 5, DW = 8, CB = 53, BC = 2, PA = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tx_en_n = 1'b1, tx_soc = 1'b0, out_ready = 1'b0;
   logic [AW-1:0] tx_addr = '0;
   logic [DW-1:0] tx_data = '0;
   logic tx_clav, frm_err, out_first, out_valid;
   logic [DW-1:0] out_data;

   int total = 0, bad = 0;
   bit done = 0;
   logic [DW:0] exp_q [0:1023];
   int wp = 0, rp = 0;

   always #2.5 clk = ~clk;

   cellbus_tx_port #(.ADDR_W(AW), .DATA_W(DW), .CELL_BYTES(CB), .BUF_CELLS(BC), .PORT_ADDR(PA))
   i_cellbus_tx_port (
      .clk(clk), .rst_n(rst_n), .tx_en_n(tx_en_n), .tx_addr(tx_addr), .tx_data(tx_data),
      .tx_soc(tx_soc), .tx_clav(tx_clav), .frm_err(frm_err), .out_data(out_data),
      .out_first(out_first), .out_valid(out_valid), .out_ready(out_ready)
   );

   function automatic logic [DW-1:0] pat(int seed, int i);
      return DW'(seed * 13 + i * 7 + 1);
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   task automatic drive(bit en_n, int addr, bit soc, logic [DW-1:0] d);
      @(negedge clk);
      tx_en_n = en_n; tx_addr = AW'(addr); tx_soc = soc; tx_data = d;
   endtask

   task automatic idle();
      drive(1'b1, 0, 1'b0, '0);
   endtask

   task automatic push_cell(int seed);
      for (int i = 0; i < CB; i++) begin
         exp_q[wp] = {i == 0, pat(seed, i)};
         wp++;
      end
   endtask

   // Send one cell; gap inserts an enable-high junk byte between bytes.
   task automatic send_cell(int seed, int addr, bit gap, bit clav_chk);
      for (int i = 0; i < CB; i++) begin
         drive(1'b0, addr, i == 0, pat(seed, i));
         if (clav_chk) chk(tx_clav == 1'b1, "R7 clav held", tx_clav, 1);
         if (gap) drive(1'b1, addr, 1'b1, 8'hEE);
      end
      idle();
   endtask

   // Pop everything; full_mode checks clav recovery from a full two-cell buffer.
   task automatic drain(bit full_mode);
      int n = 0;
      @(negedge clk);
      for (int k = 0; k < 400; k++) begin
         if (!out_valid) break;
         chk(out_data == exp_q[rp][DW-1:0], "R8 data", out_data, exp_q[rp][DW-1:0]);
         chk(out_first == exp_q[rp][DW], "R8 first", out_first, exp_q[rp][DW]);
         if (full_mode) chk(tx_clav == (n >= CB), "R7 clav recover", tx_clav, n >= CB);
         rp++; n++;
         out_ready = 1'b1;
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(rp == wp, "R8 count", rp, wp);
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(tx_clav == 1'b1, "R1 clav", tx_clav, 1);
      chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
      chk(frm_err == 1'b0, "R1 err", frm_err, 0);

      // R2 address sweep incl. null address; port 5 cell uses enable gaps
      for (int a = 0; a < 32; a++) begin
         send_cell(a, a, a == PA, 1'b0);
         if (a == PA) push_cell(a);
         chk(out_valid == (a == PA), "R2 select", out_valid, a == PA);
         drain(1'b0);
      end

      // R3 bytes before any start-of-cell, and after a cell's end
      for (int i = 0; i < 10; i++) drive(1'b0, PA, 1'b0, 8'h55);
      idle();
      chk(out_valid == 1'b0, "R3 pre-soc", out_valid, 0);
      send_cell(40, PA, 1'b0, 1'b0);
      push_cell(40);
      for (int i = 0; i < 60; i++) drive(1'b0, PA, 1'b0, 8'hA5);
      idle();
      drain(1'b0);
      chk(out_valid == 1'b0, "R3 post-cell", out_valid, 0);

      // R5 commit timing, R4 byte count
      for (int i = 0; i < CB - 1; i++) drive(1'b0, PA, i == 0, pat(41, i));
      drive(1'b1, PA, 1'b0, '0);
      chk(out_valid == 1'b0, "R5 not before last", out_valid, 0);
      drive(1'b0, PA, 1'b0, pat(41, CB - 1));
      idle();
      chk(out_valid == 1'b1, "R5 visible after last", out_valid, 1);
      push_cell(41);
      drain(1'b0);

      // R6 early start-of-cell
      for (int i = 0; i < 20; i++) drive(1'b0, PA, i == 0, 8'h33);
      drive(1'b0, PA, 1'b1, pat(42, 0));
      chk(frm_err == 1'b0, "R6 err not early", frm_err, 0);
      drive(1'b0, PA, 1'b0, pat(42, 1));
      chk(frm_err == 1'b1, "R6 err pulse", frm_err, 1);
      for (int i = 2; i < CB; i++) begin
         drive(1'b0, PA, 1'b0, pat(42, i));
         if (i == 2) chk(frm_err == 1'b0, "R6 err one cycle", frm_err, 0);
      end
      idle();
      push_cell(42);
      drain(1'b0);

      // R7 clav over a full buffer, R9 refused cell
      send_cell(43, PA, 1'b0, 1'b1);
      push_cell(43);
      chk(tx_clav == 1'b1, "R7 one cell stored", tx_clav, 1);
      send_cell(44, PA, 1'b0, 1'b1);
      push_cell(44);
      chk(tx_clav == 1'b0, "R7 full", tx_clav, 0);
      send_cell(45, PA, 1'b0, 1'b0);
      chk(frm_err == 1'b0, "R9 no err", frm_err, 0);
      chk(tx_clav == 1'b0, "R9 still full", tx_clav, 0);
      drain(1'b1);
      chk(tx_clav == 1'b1, "R7 empty", tx_clav, 1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule